// File: doc/BRIEF.md
# Double Syndrome Generator with Counter-Seeded Scrambling

This block builds one candidate double syndrome for a code-based signing loop. It takes a fixed 144-bit hashed message and a local attempt counter. It scrambles the message bit by bit with a pseudo-random stream from a 25-stage shift register that is seeded from the counter. Each scrambled bit decides whether one 288-bit row of a stored matrix is folded into the result. The result is eighteen 16-bit field coefficients. A failed decoding attempt is followed by a counter increment and a new start, which gives a fresh syndrome from the same message.

The matrix is loaded once through a simple row write port. A run takes one seeding cycle and then one row per cycle. The matrix read is registered, and the row address is issued one cycle ahead, so the accumulation has no idle cycles.

Top module: `syndromeGen`

## Requirements
- R1: On a rising edge, `cntClear` sets `attemptIdx` to 0. Otherwise `cntIncr` adds 1 to it. Clear wins when both inputs are high. Reset gives 0.
- R2: A `start` sampled while idle is the seeding cycle. The scrambler state takes the value of `attemptIdx`, or 1 when that value is 0. All eighteen accumulators clear to zero on the same edge.
- R3: The scrambler output is stage 0. On each step, every stage takes the value of the stage above it. Stage 24 takes stage 0 XOR stage 3. This is the trinomial x^25+x^22+1 in Fibonacci form. Row k uses the k-th output bit: k=0 is stage 0 of the seed, and k=1 is stage 0 after one step.
- R4: For k = 0..143, row k is XORed into the accumulators when hash bit k XOR stream bit k equals 1. Coefficient c sits in bits [16c+15:16c], both in a row and in `syndOut`.
- R5: `done` goes high for exactly one cycle, after the 145th rising edge counted from the edge that sampled `start`. `syndOut` then holds the finished syndrome.
- R6: A `start` that arrives during a run is ignored. The timing and the result of the current run do not change.
- R7: While idle, `syndOut` holds its value. Changes to `hashIn` and writes to the matrix do not alter it.
- R8: A write with `wrEn` high stores `wrData` as row `wrAddr` (0..143). Later runs use the new row.
- R9: Changing the counter during a run does not affect that run. The seed is taken only in the seeding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hashIn | input | 144 | Hashed message; must stay stable during a run |
| start | input | 1 | Begin a run (taken when idle) |
| cntIncr | input | 1 | Increment attempt counter |
| cntClear | input | 1 | Clear attempt counter |
| wrEn | input | 1 | Matrix row write enable |
| wrAddr | input | 8 | Matrix row index |
| wrData | input | 288 | Matrix row contents |
| syndOut | output | 288 | Eighteen 16-bit syndrome coefficients |
| done | output | 1 | One-cycle completion pulse |
| attemptIdx | output | 25 | Attempt counter value |

## Verification
The assertions check the following on every cycle:
- the counter clear and increment behaviour;
- zeroed accumulators right after seeding;
- a nonzero scrambler state throughout a run;
- a row index that advances by one each run cycle;
- a single-cycle `done` that follows the last row;
- a stable `syndOut` while idle.

Whether the value that is accumulated is correct for a given message, counter and matrix can only be shown by the bench. It compares against an independent model of the scrambler and of the masked XOR. The bench also covers starts and counter changes in the middle of a run, rewritten rows, and the zero-seed substitution.

// File: rtl/syndGenPkg.sv
package syndGenPkg;
  typedef struct packed {
    logic init;     // seeding cycle
    logic accStep;  // one row accumulation cycle
  } ctrlStb_t;
endpackage

// File: rtl/syndCtrl.sv
module syndCtrl
  import syndGenPkg::*;
#(
  parameter int ROWS = 144,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output ctrlStb_t      stb,
  output logic [RW-1:0] rowIdx,
  output logic [RW-1:0] rdAddr,
  output logic          runActive,
  output logic          done
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic          running;
  logic [RW-1:0] rowCnt;
  logic          lastRow;

  assign lastRow     = running && (rowCnt == LAST_ROW);
  assign stb.init    = start && !running;
  assign stb.accStep = running;
  assign rowIdx      = rowCnt;
  assign runActive   = running;

  // Row address one cycle ahead of its use
  always_comb begin
    if (stb.init || lastRow) rdAddr = '0;
    else                     rdAddr = rowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      rowCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= lastRow;
      if (stb.init) begin
        running <= 1'b1;
        rowCnt  <= '0;
      end else if (running) begin
        if (lastRow) running <= 1'b0;
        rowCnt <= rowCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/syndDatapath.sv
module syndDatapath
  import syndGenPkg::*;
#(
  parameter int ROWS     = 144,
  parameter int NCOEF    = 18,
  parameter int CW       = 16,
  parameter int LFSR_LEN = 25,
  parameter int TAP      = 3,
  localparam int RW      = $clog2(ROWS),
  localparam int ROW_W   = NCOEF * CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStb_t            stb,
  input  logic [RW-1:0]       rowIdx,
  input  logic [RW-1:0]       rdAddr,
  input  logic [ROWS-1:0]     hashIn,
  input  logic                cntIncr,
  input  logic                cntClear,
  input  logic                wrEn,
  input  logic [RW-1:0]       wrAddr,
  input  logic [ROW_W-1:0]    wrData,
  output logic [ROW_W-1:0]    syndOut,
  output logic [LFSR_LEN-1:0] attemptIdx,
  output logic [LFSR_LEN-1:0] lfsrState
);
  logic [ROW_W-1:0]    matRam [ROWS];
  logic [ROW_W-1:0]    rdRow;
  logic [LFSR_LEN-1:0] lfsr;
  logic [LFSR_LEN-1:0] seedVal;
  logic                maskBit;

  // Matrix storage: one write row, one registered read row
  always_ff @(posedge clk) begin
    if (wrEn && (32'(wrAddr) < ROWS)) matRam[wrAddr] <= wrData;
    rdRow <= matRam[rdAddr];
  end

  // Attempt counter
  always_ff @(posedge clk) begin
    if (!rst_n || cntClear) attemptIdx <= '0;
    else if (cntIncr)       attemptIdx <= attemptIdx + 1'b1;
  end

  assign seedVal = (attemptIdx == '0) ? LFSR_LEN'(1) : attemptIdx;

  // Fibonacci scrambler
  always_ff @(posedge clk) begin
    if (!rst_n)           lfsr <= LFSR_LEN'(1);
    else if (stb.init)    lfsr <= seedVal;
    else if (stb.accStep) lfsr <= {lfsr[0] ^ lfsr[TAP], lfsr[LFSR_LEN-1:1]};
  end

  assign lfsrState = lfsr;
  assign maskBit   = hashIn[rowIdx] ^ lfsr[0];

  // One accumulator lane per coefficient
  for (genvar c = 0; c < NCOEF; c++) begin : g_lane
    logic [CW-1:0] accLane;
    always_ff @(posedge clk) begin
      if (!rst_n || stb.init)          accLane <= '0;
      else if (stb.accStep && maskBit) accLane <= accLane ^ rdRow[c*CW +: CW];
    end
    assign syndOut[c*CW +: CW] = accLane;
  end
endmodule

// File: rtl/syndromeGen.sv
module syndromeGen
  import syndGenPkg::*;
#(
  parameter int ROWS     = 144,
  parameter int NCOEF    = 18,
  parameter int CW       = 16,
  parameter int LFSR_LEN = 25,
  parameter int TAP      = 3,
  localparam int RW      = $clog2(ROWS),
  localparam int ROW_W   = NCOEF * CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROWS-1:0]     hashIn,
  input  logic                start,
  input  logic                cntIncr,
  input  logic                cntClear,
  input  logic                wrEn,
  input  logic [RW-1:0]       wrAddr,
  input  logic [ROW_W-1:0]    wrData,
  output logic [ROW_W-1:0]    syndOut,
  output logic                done,
  output logic [LFSR_LEN-1:0] attemptIdx
);
  ctrlStb_t            ctrlStb;
  logic [RW-1:0]       rowIdx;
  logic [RW-1:0]       rdAddr;
  logic                runActive;
  logic [LFSR_LEN-1:0] lfsrState;

  syndCtrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stb(ctrlStb),
    .rowIdx(rowIdx), .rdAddr(rdAddr), .runActive(runActive), .done(done)
  );

  syndDatapath #(
    .ROWS(ROWS), .NCOEF(NCOEF), .CW(CW), .LFSR_LEN(LFSR_LEN), .TAP(TAP)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(ctrlStb), .rowIdx(rowIdx), .rdAddr(rdAddr),
    .hashIn(hashIn), .cntIncr(cntIncr), .cntClear(cntClear),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syndOut(syndOut), .attemptIdx(attemptIdx), .lfsrState(lfsrState)
  );
endmodule

// File: rtl/syndGenChk.sv
module syndGenChk #(
  parameter int ROWS     = 144,
  parameter int ROW_W    = 288,
  parameter int LFSR_LEN = 25,
  localparam int RW      = $clog2(ROWS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                init,
  input logic                runActive,
  input logic [RW-1:0]       rowIdx,
  input logic                done,
  input logic                cntIncr,
  input logic                cntClear,
  input logic [LFSR_LEN-1:0] attemptIdx,
  input logic [LFSR_LEN-1:0] lfsrState,
  input logic [ROW_W-1:0]    syndOut
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cntClear |=> attemptIdx == '0);  // R1
  AST_CNT_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntClear && cntIncr) |=> attemptIdx == $past(attemptIdx) + 1'b1);  // R1
  AST_SEED_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> syndOut == '0);  // R2
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    runActive |-> lfsrState != '0);  // R3
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (runActive && rowIdx != LAST_ROW) |=> (runActive && rowIdx == $past(rowIdx) + 1'b1));  // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (runActive && rowIdx == LAST_ROW) |=> (done && !runActive));  // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!runActive && !init) |=> $stable(syndOut));  // R7
endmodule

bind syndromeGen syndGenChk #(
  .ROWS(ROWS), .ROW_W(ROW_W), .LFSR_LEN(LFSR_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init(ctrlStb.init), .runActive(runActive),
  .rowIdx(rowIdx), .done(done), .cntIncr(cntIncr), .cntClear(cntClear),
  .attemptIdx(attemptIdx), .lfsrState(lfsrState), .syndOut(syndOut)
);

// File: tb/tb_syndromeGen.sv
module tb_syndromeGen;
  localparam int ROWS = 144;
  localparam int ROW_W = 288;
  localparam int LL = 25;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [ROWS-1:0]  hashIn = '0;
  logic             start = 1'b0, cntIncr = 1'b0, cntClear = 1'b0, wrEn = 1'b0;
  logic [7:0]       wrAddr = '0;
  logic [ROW_W-1:0] wrData = '0;
  logic [ROW_W-1:0] syndOut;
  logic             done;
  logic [LL-1:0]    attemptIdx;

  logic [ROW_W-1:0] refMat [ROWS];
  logic [LL-1:0]    refCnt = '0;
  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  syndromeGen dut (.*);

  task automatic check(input bit ok, input string tag, input logic [ROW_W-1:0] act,
                       input logic [ROW_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: counter-seeded scrambler and masked row accumulation (R2, R3, R4)
  function automatic logic [ROW_W-1:0] model(input logic [ROWS-1:0] h, input logic [LL-1:0] c);
    logic [LL-1:0] s = (c == '0) ? LL'(1) : c;
    logic [ROW_W-1:0] acc = '0;
    for (int k = 0; k < ROWS; k++) begin
      if (h[k] ^ s[0]) acc ^= refMat[k];
      s = {s[0] ^ s[3], s[LL-1:1]};
    end
    return acc;
  endfunction

  function automatic logic [ROW_W-1:0] rndRow();
    logic [ROW_W-1:0] r;
    for (int w = 0; w < 9; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [ROWS-1:0] rndHash();
    logic [ROWS-1:0] r;
    for (int w = 0; w < 5; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic writeRow(input int a, input logic [ROW_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'(a); wrData = d;
    refMat[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic bump(input bit clr, input bit inc);
    @(negedge clk);
    cntClear = clr; cntIncr = inc;
    @(negedge clk);
    cntClear = 1'b0; cntIncr = 1'b0;
    if (clr) refCnt = '0; else if (inc) refCnt = refCnt + 1'b1;
    check(attemptIdx == refCnt, "R1 counter", ROW_W'(attemptIdx), ROW_W'(refCnt));
  endtask

  task automatic runCheck(input string tag, input bit midStart, input bit midIncr);
    logic [ROW_W-1:0] exp;
    @(negedge clk);
    start = 1'b1;
    exp = model(hashIn, refCnt);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 143; k++) begin
      @(negedge clk);
      start   = midStart && (k == 50);  // R6
      cntIncr = midIncr && (k == 60);   // R9
      if (midIncr && k == 60) refCnt = refCnt + 1'b1;
    end
    check(done == 1'b0, {tag, " R5 done early"}, ROW_W'(done), '0);
    @(negedge clk);
    check(done == 1'b1, {tag, " R5 done timing"}, ROW_W'(done), 1);
    check(syndOut == exp, {tag, " R4 syndrome"}, syndOut, exp);
    @(negedge clk);
    check(done == 1'b0, {tag, " R5 done pulse width"}, ROW_W'(done), '0);
  endtask

  initial begin
    logic [ROW_W-1:0] held;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && syndOut == '0, "reset outputs", syndOut, '0);
    check(attemptIdx == '0, "R1 reset counter", ROW_W'(attemptIdx), '0);

    // Zero matrix: result must be zero
    for (int a = 0; a < ROWS; a++) writeRow(a, '0);
    hashIn = rndHash();
    runCheck("zero matrix", 1'b0, 1'b0);

    for (int a = 0; a < ROWS; a++) writeRow(a, rndRow());

    // Counter 0 -> seed 1 substitution (R2)
    hashIn = rndHash();
    runCheck("R2 zero seed", 1'b0, 1'b0);
    hashIn = '0;
    runCheck("R3 stream only", 1'b0, 1'b0);
    hashIn = '1;
    bump(1'b0, 1'b1);
    runCheck("R3 inverted stream cnt1", 1'b0, 1'b0);

    for (int n = 0; n < 4; n++) begin
      hashIn = rndHash();
      for (int b = 0; b < n + 1; b++) bump(1'b0, 1'b1);
      runCheck("R4 random", 1'b0, 1'b0);
    end

    runCheck("R6 start mid-run", 1'b1, 1'b0);
    runCheck("R9 incr mid-run", 1'b0, 1'b1);
    check(attemptIdx == refCnt, "R9 counter advanced", ROW_W'(attemptIdx), ROW_W'(refCnt));

    // R7: idle hold against hash and matrix changes
    held = syndOut;
    hashIn = ~hashIn;
    writeRow(0, rndRow());
    writeRow(143, rndRow());
    repeat (5) @(negedge clk);
    check(syndOut == held, "R7 idle hold", syndOut, held);

    // R8: rewritten rows are used
    hashIn = rndHash();
    runCheck("R8 rewritten rows", 1'b0, 1'b0);

    bump(1'b1, 1'b1);
    runCheck("R1 clear wins then zero seed", 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule